// File: doc/BRIEF.md
# Duty Ratio Best-Fit Search Engine

This block takes a requested rate, a base rate and a longest allowed period. It then picks the pair of ON and OFF counts whose duty ratio brings the effective rate `base * OFF / (ON + OFF)` closest to the request. Every whole period length from the clamped maximum down to 1 is tried. For each period the block works out the OFF count that the request implies and the rate that this OFF count really gives. It keeps the candidate with the smallest absolute error. A candidate with the same error also replaces the kept one, so the shortest period wins a tie.

A single shared restoring divider does all the work, one quotient bit per cycle. Each candidate takes two divisions: one for the OFF count and one for the achieved rate. A caller pulses `start` while the block is idle. `busy` then stays high for the whole search. `done` pulses for one cycle with the result already on the outputs, and the outputs hold that result until the next accepted start.

States: `ST_IDLE` (waits for start), `ST_LOAD` (checks for an empty search), `ST_OFF_GO` / `ST_OFF_WAIT` (OFF-count division), `ST_RATE_GO` / `ST_RATE_WAIT` (achieved-rate division), `ST_CMP` (error compare and period step), `ST_DONE` (result pulse). The transitions are as follows:
- IDLE→LOAD on start.
- LOAD→DONE when the base is zero or the period is zero. Otherwise LOAD→OFF_GO.
- OFF_GO→OFF_WAIT, then OFF_WAIT→RATE_GO when the divider finishes.
- RATE_GO→RATE_WAIT, then RATE_WAIT→CMP when the divider finishes.
- CMP→OFF_GO while the period is above 1, and CMP→DONE at period 1.
- DONE→LOAD on start. Otherwise DONE→IDLE.

Top module: `dsr_bestfit`

## Requirements
- R1: After reset `busy` = 0, `done` = 0, `on_cnt` = 0, `off_cnt` = 1 and `ach_rate` = 0.
- R2: For a period p, the candidate OFF count is floor(req*p/base) kept to its low 8 bits. The ON count is (p − OFF) mod 256, and the achieved rate is floor(base*OFF/p).
- R3: The result is the candidate with the smallest |achieved − req| over all periods from the clamped maximum down to 1. The starting candidate (ON 0, OFF 1, rate = base) counts as well.
- R4: A candidate whose error equals the best error so far replaces it, so among equal errors the shortest period is reported.
- R5: A `max_period` above 255 is treated as 255. A `max_period` of 0 reports the starting candidate (ON 0, OFF 1, rate = base).
- R6: A base rate of 0 reports ON 0, OFF 1, rate 0, with `done` at most two cycles after the start edge.
- R7: After an accepted start, `busy` is high from the next cycle until the search ends. `done` is high for exactly one cycle, and `busy` is low while `done` is high.
- R8: A `start` that arrives while `busy` is high is ignored. The running search finishes with its own inputs.
- R9: `on_cnt`, `off_cnt` and `ach_rate` change only in the cycle in which `done` rises, and they hold from then until the next result.
- R10: `ach_rate` is 32 bits wide and carries rates above the base rate (a request above the base) without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; sampled only while not busy |
| req_rate | input | 24 | Requested rate, unsigned |
| base_rate | input | 24 | Full base rate, unsigned |
| max_period | input | 9 | Longest period to try; values above 255 are clamped |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse; results valid |
| on_cnt | output | 8 | Chosen ON count |
| off_cnt | output | 8 | Chosen OFF count |
| ach_rate | output | 32 | Rate achieved by the chosen pair |

## Verification
`busy` is due one cycle after the edge that samples `start`. The bench checks it at the falling edge that follows. A search takes about seventy cycles per period tried, so the bench waits for `done` at each falling edge instead of counting cycles. It samples all three results at the falling edge where `done` is first seen. It checks `done` low and unchanged outputs one cycle later and again several idle cycles later. The zero-base search must show `done` by the second falling edge after the start edge.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int RATE_W = 24;
    localparam int PER_W  = 8;
    localparam int PROD_W = RATE_W + PER_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_OFF_GO,
        ST_OFF_WAIT,
        ST_RATE_GO,
        ST_RATE_WAIT,
        ST_CMP,
        ST_DONE
    } dsr_state_t;
endpackage

// File: rtl/dsr_divider.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles per division.
module dsr_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    always_comb begin
        trial = {rem_q, quo_q[NUM_W-1]};
        diff  = trial - {1'b0, den};
        fits  = (trial >= {1'b0, den});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= '0;
                quo_q <= num;
                cnt_q <= CNT_W'(NUM_W);
            end else if (cnt_q != '0) begin
                quo_q <= {quo_q[NUM_W-2:0], fits};
                rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) done <= 1'b1;
            end
        end
    end

    assign quot = quo_q;
endmodule

// File: rtl/dsr_errcmp.sv
// Decides whether a candidate rate is at least as close to the request as the kept one.
module dsr_errcmp #(
    parameter int ACH_W = 32,
    parameter int REQ_W = 24
) (
    input  logic [ACH_W-1:0] cand_rate,
    input  logic [ACH_W-1:0] best_rate,
    input  logic [REQ_W-1:0] req,
    output logic             take
);
    logic [ACH_W-1:0] req_x;
    logic [ACH_W-1:0] cand_err;
    logic [ACH_W-1:0] best_err;

    always_comb begin
        req_x    = ACH_W'(req);
        cand_err = (cand_rate >= req_x) ? (cand_rate - req_x) : (req_x - cand_rate);
        best_err = (best_rate >= req_x) ? (best_rate - req_x) : (req_x - best_rate);
        take     = (cand_err <= best_err);
    end
endmodule

// File: rtl/dsr_bestfit.sv
module dsr_bestfit
    import dsr_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int PW = PER_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] req_rate,
    input  logic [RW-1:0] base_rate,
    input  logic [PW:0]   max_period,
    output logic          busy,
    output logic          done,
    output logic [PW-1:0] on_cnt,
    output logic [PW-1:0] off_cnt,
    output logic [RW+PW-1:0] ach_rate
);
    localparam int AW = RW + PW;
    localparam logic [PW:0] PER_MAX = {1'b0, {PW{1'b1}}};

    dsr_state_t state_q, state_d;

    logic [RW-1:0] req_q, base_q;
    logic [PW-1:0] per_q;
    logic [PW-1:0] cand_on_q, cand_off_q;
    logic [AW-1:0] cand_rate_q;
    logic [PW-1:0] best_on_q, best_off_q;
    logic [AW-1:0] best_rate_q;
    logic [PW-1:0] win_on, win_off;
    logic [AW-1:0] win_rate;
    logic [PW-1:0] per_clamped;

    logic          div_start, div_done;
    logic [AW-1:0] div_num, div_quot;
    logic [RW-1:0] div_den;
    logic          take;
    logic          accept;

    assign accept      = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign per_clamped = (max_period > PER_MAX) ? PER_MAX[PW-1:0] : max_period[PW-1:0];

    // divider operand selection
    always_comb begin
        div_start = (state_q == ST_OFF_GO) || (state_q == ST_RATE_GO);
        if (state_q == ST_RATE_GO || state_q == ST_RATE_WAIT) begin
            div_num = AW'(base_q) * AW'(cand_off_q);
            div_den = RW'(per_q);
        end else begin
            div_num = AW'(req_q) * AW'(per_q);
            div_den = base_q;
        end
    end

    dsr_divider #(.NUM_W(AW), .DEN_W(RW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quot  (div_quot)
    );

    dsr_errcmp #(.ACH_W(AW), .REQ_W(RW)) u_cmp (
        .cand_rate (cand_rate_q),
        .best_rate (best_rate_q),
        .req       (req_q),
        .take      (take)
    );

    always_comb begin
        win_on   = take ? cand_on_q   : best_on_q;
        win_off  = take ? cand_off_q  : best_off_q;
        win_rate = take ? cand_rate_q : best_rate_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_LOAD;
            ST_LOAD:      state_d = (base_q == '0 || per_q == '0) ? ST_DONE : ST_OFF_GO;
            ST_OFF_GO:    state_d = ST_OFF_WAIT;
            ST_OFF_WAIT:  if (div_done) state_d = ST_RATE_GO;
            ST_RATE_GO:   state_d = ST_RATE_WAIT;
            ST_RATE_WAIT: if (div_done) state_d = ST_CMP;
            ST_CMP:       state_d = (per_q == PW'(1)) ? ST_DONE : ST_OFF_GO;
            ST_DONE:      state_d = start ? ST_LOAD : ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q       <= '0;
            base_q      <= '0;
            per_q       <= '0;
            cand_on_q   <= '0;
            cand_off_q  <= '0;
            cand_rate_q <= '0;
            best_on_q   <= '0;
            best_off_q  <= PW'(1);
            best_rate_q <= '0;
            on_cnt      <= '0;
            off_cnt     <= PW'(1);
            ach_rate    <= '0;
        end else begin
            if (accept) begin
                req_q       <= req_rate;
                base_q      <= base_rate;
                per_q       <= per_clamped;
                best_on_q   <= '0;
                best_off_q  <= PW'(1);
                best_rate_q <= AW'(base_rate);
            end
            unique case (state_q)
                ST_LOAD: begin
                    if (base_q == '0 || per_q == '0) begin
                        on_cnt   <= '0;
                        off_cnt  <= PW'(1);
                        ach_rate <= AW'(base_q);
                    end
                end
                ST_OFF_WAIT: begin
                    if (div_done) begin
                        cand_off_q <= div_quot[PW-1:0];
                        cand_on_q  <= per_q - div_quot[PW-1:0];
                    end
                end
                ST_RATE_WAIT: begin
                    if (div_done) cand_rate_q <= div_quot;
                end
                ST_CMP: begin
                    best_on_q   <= win_on;
                    best_off_q  <= win_off;
                    best_rate_q <= win_rate;
                    per_q       <= per_q - 1'b1;
                    if (per_q == PW'(1)) begin
                        on_cnt   <= win_on;
                        off_cnt  <= win_off;
                        ach_rate <= win_rate;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done = (state_q == ST_DONE);
endmodule

// File: rtl/dsr_bestfit_chk.sv
module dsr_bestfit_chk #(
    parameter int PW = 8,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [PW-1:0] on_cnt,
    input logic [PW-1:0] off_cnt,
    input logic [AW-1:0] ach_rate
);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_low_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(on_cnt) && $stable(off_cnt) && $stable(ach_rate)));

    p_period_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (PW'(on_cnt + off_cnt) != '0));
endmodule

bind dsr_bestfit dsr_bestfit_chk #(.PW(PW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .on_cnt   (on_cnt),
    .off_cnt  (off_cnt),
    .ach_rate (ach_rate)
);

// File: tb/test_dsr_bestfit.sv
module test_dsr_bestfit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    localparam int WAIT_MAX = 30000;
    localparam int WATCHDOG = 150000;

    localparam int V_BASE[NV] = '{100, 1000, 1000, 100, 300, 7, 1, 255, 500, 0};
    localparam int V_REQ [NV] = '{50, 1000, 0, 300, 100, 3, 100, 1, 7, 9};
    localparam int V_MAX [NV] = '{4, 10, 5, 3, 7, 5, 3, 300, 0, 20};
    localparam int V_ON  [NV] = '{1, 0, 1, 254, 2, 2, 157, 254, 0, 0};
    localparam int V_OFF [NV] = '{1, 1, 0, 3, 1, 1, 100, 1, 1, 1};
    localparam int V_RATE[NV] = '{50, 1000, 0, 300, 100, 2, 100, 1, 500, 0};
    localparam string V_TAG[NV] = '{"R4", "R3", "R2", "R10", "R3", "R4", "R2", "R5", "R5", "R6"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] req_rate = '0;
    logic [23:0] base_rate = '0;
    logic [8:0]  max_period = '0;
    logic        busy, done;
    logic [7:0]  on_cnt, off_cnt;
    logic [31:0] ach_rate;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int waited;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    dsr_bestfit i_dsr_bestfit (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_rate   (req_rate),
        .base_rate  (base_rate),
        .max_period (max_period),
        .busy       (busy),
        .done       (done),
        .on_cnt     (on_cnt),
        .off_cnt    (off_cnt),
        .ach_rate   (ach_rate)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_res(input string tag, input int e_on, input int e_off, input int e_rate);
        check(on_cnt == 8'(e_on), tag, "on_cnt", on_cnt, e_on);
        check(off_cnt == 8'(e_off), tag, "off_cnt", off_cnt, e_off);
        check(ach_rate == 32'(e_rate), tag, "ach_rate", ach_rate, e_rate);
    endtask

    task automatic launch(input int b, input int r, input int m);
        @(negedge clk);
        base_rate  = 24'(b);
        req_rate   = 24'(r);
        max_period = 9'(m);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        check(busy == 1'b1, "R7", "busy after start", busy, 1);
    endtask

    task automatic wait_done();
        waited = 1;
        while (!done && waited < WAIT_MAX) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R7", "done reached", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy", busy, 0);
        check(done == 1'b0, "R1", "done", done, 0);
        check_res("R1", 0, 1, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            launch(V_BASE[v], V_REQ[v], V_MAX[v]);
            wait_done();
            check(busy == 1'b0, "R7", "busy at done", busy, 0);
            check_res(V_TAG[v], V_ON[v], V_OFF[v], V_RATE[v]);
            if (v == 9) check(waited <= 2, "R6", "cycles to done", waited, 2);
            @(negedge clk);
            check(done == 1'b0, "R7", "done one cycle", done, 0);
            check_res("R9", V_ON[v], V_OFF[v], V_RATE[v]);
        end

        // R8: start while busy is ignored
        launch(300, 100, 7);
        repeat (20) @(negedge clk);
        base_rate  = 24'd0;
        req_rate   = 24'd5;
        max_period = 9'd2;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        check(busy == 1'b1, "R8", "still busy", busy, 1);
        wait_done();
        check_res("R8", 2, 1, 100);

        // R9: held across idle cycles
        repeat (8) @(negedge clk);
        check(done == 1'b0, "R9", "done idle", done, 0);
        check_res("R9", 2, 1, 100);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule